// File: doc/BRIEF.md
# Rotate-Through-Carry Unit

This block rotates an operand through the carry flag. The carry bit sits above the operand's top bit, so the rotation runs over a ring one bit wider than the operand. The block is purely combinational. It takes an operand, a raw count byte, a direction bit, a width select and the incoming carry and overflow flags. It returns the rotated value and the updated carry and overflow flags. It serves 8, 16 and 32-bit operands.

Each operand width has its own lane, and every lane computes its result in parallel. The width select picks which lane drives the outputs. Each lane first reduces the count to an effective count in the range 0..width. It then rotates its (width+1)-bit ring by that amount in the requested direction. The overflow flag is rewritten only when the effective count is exactly one. A count that reduces to zero leaves every output equal to its input.

Top module: `rtc_rotate_unit`

## Requirements
- R1: Only the low 5 bits of `cnt_raw` are used; the upper 3 bits have no effect on any output.
- R2: The effective count is the masked count modulo 9 for `width_sel`=0 (8-bit) and modulo 17 for `width_sel`=1 (16-bit); for `width_sel`=2 (32-bit) the masked count is used as it is.
- R3: When the effective count is zero, `rslt_out` equals the operand of the selected width, `carry_out` equals `carry_in` and `ovf_out` equals `ovf_in`.
- R4: Left rotate (`rot_right`=0) by n at width w: `carry_out` is operand bit w-n, `carry_in` lands in result bit n-1, operand bits below w-n move up by n, and operand bits above w-n wrap into result bits n-2..0.
- R5: Right rotate (`rot_right`=1) by n at width w: `carry_out` is operand bit n-1, `carry_in` lands in result bit w-n, and the remaining bits follow a rotation of the (w+1)-bit ring to the right by n.
- R6: Left rotate with effective count 1: `ovf_out` is `carry_out` XOR the result's top bit (bit w-1).
- R7: Right rotate with effective count 1: `ovf_out` is `carry_in` XOR the operand's original top bit (bit w-1).
- R8: For any effective count other than 1, `ovf_out` equals `ovf_in`.
- R9: Result bits at and above the selected width are zero. `width_sel`=3 behaves exactly as `width_sel`=2.
- R10: Operand bits at and above the selected width have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opd_in | input | 32 | Operand; only the low w bits are used |
| cnt_raw | input | 8 | Raw rotate count |
| rot_right | input | 1 | 0 = rotate left, 1 = rotate right |
| width_sel | input | 2 | 0 = 8-bit, 1 = 16-bit, 2 or 3 = 32-bit |
| carry_in | input | 1 | Incoming carry flag |
| ovf_in | input | 1 | Incoming overflow flag |
| rslt_out | output | 32 | Rotated value, zero above the selected width |
| carry_out | output | 1 | Updated carry flag |
| ovf_out | output | 1 | Updated overflow flag |

## Verification
All three results are combinational, so each one is due in the same cycle as the inputs that produce it, with no register delay. The bench changes the inputs on the falling clock edge. It samples `rslt_out`, `carry_out` and `ovf_out` one nanosecond later, after they settle and well before the next rising edge. Expected values come from a reference model that steps the (w+1)-bit ring one position at a time. A few hand-worked vectors pin down the exact bit positions.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
   // Width select codes; any code at or above the lane count maps to the widest lane.
   localparam int unsigned SEL_W      = 2;
   localparam int unsigned CNT_W      = 8;
   localparam int unsigned CNT_MASK_W = 5;

   function automatic int unsigned eff_width(input int unsigned lane_w);
      return $clog2(lane_w + 2);
   endfunction
endpackage

// File: rtl/rtc_count_reduce.sv
module rtc_count_reduce #(
   parameter int unsigned LANE_W = 8,
   parameter int unsigned CNT_W  = 8,
   parameter int unsigned MASK_W = 5,
   localparam int unsigned EFF_W = rtc_pkg::eff_width(LANE_W)
) (
   input  logic [CNT_W-1:0] cnt_raw,
   output logic [EFF_W-1:0] cnt_eff
);
   logic [MASK_W-1:0] masked;

   // R1: keep only the low MASK_W bits
   assign masked = cnt_raw[MASK_W-1:0];

   generate
      if (MASK_W > CNT_W) begin : g_bad_mask
         $error("rtc_count_reduce: MASK_W exceeds CNT_W");
      end
      if ((1 << MASK_W) <= LANE_W + 1) begin : g_direct
         // masked count never reaches the ring size: no reduction needed
         assign cnt_eff = EFF_W'(masked);
      end else begin : g_modulo
         assign cnt_eff = EFF_W'(32'(masked) % (LANE_W + 1));
      end
   endgenerate

   always_comb begin
      AST_EFF_RANGE: assert (32'(cnt_eff) <= LANE_W)
         else $error("effective count out of ring range"); // R2
   end
endmodule

// File: rtl/rtc_ring_rotator.sv
module rtc_ring_rotator #(
   parameter int unsigned LANE_W = 8,
   localparam int unsigned EFF_W  = rtc_pkg::eff_width(LANE_W),
   localparam int unsigned RING_W = LANE_W + 1
) (
   input  logic [LANE_W-1:0] val_in,
   input  logic [EFF_W-1:0]  cnt_eff,
   input  logic              go_right,
   input  logic              cf_in,
   input  logic              of_in,
   output logic [LANE_W-1:0] val_out,
   output logic              cf_out,
   output logic              of_out
);
   logic [RING_W-1:0]   ring;
   logic [2*RING_W-1:0] dbl;
   logic [2*RING_W-1:0] dbl_l;
   logic [2*RING_W-1:0] dbl_r;
   logic [RING_W-1:0]   turned;
   logic                single;

   // carry occupies the bit just above the operand's MSB
   assign ring  = {cf_in, val_in};
   assign dbl   = {ring, ring};
   assign dbl_l = dbl << cnt_eff;
   assign dbl_r = dbl >> cnt_eff;

   always_comb begin
      if (go_right) turned = dbl_r[RING_W-1:0];         // R5
      else          turned = dbl_l[2*RING_W-1:RING_W];  // R4
   end

   assign val_out = turned[LANE_W-1:0];
   assign cf_out  = turned[LANE_W];
   assign single  = (cnt_eff == EFF_W'(1));

   always_comb begin
      if (!single)       of_out = of_in;                       // R8
      else if (go_right) of_out = cf_in ^ val_in[LANE_W-1];    // R7
      else               of_out = turned[LANE_W] ^ turned[LANE_W-1]; // R6
   end

   always_comb begin
      AST_RING_POP: assert ($countones({cf_out, val_out}) == $countones({cf_in, val_in}))
         else $error("rotation lost or created ring bits"); // R4
   end
endmodule

// File: rtl/rtc_rotate_unit.sv
module rtc_rotate_unit #(
   parameter int unsigned NARROW_W  = 8,
   parameter int unsigned NUM_LANES = 3,
   localparam int unsigned DATA_W   = NARROW_W << (NUM_LANES - 1),
   localparam int unsigned SEL_W    = rtc_pkg::SEL_W,
   localparam int unsigned CNT_W    = rtc_pkg::CNT_W
) (
   input  logic [DATA_W-1:0] opd_in,
   input  logic [CNT_W-1:0]  cnt_raw,
   input  logic              rot_right,
   input  logic [SEL_W-1:0]  width_sel,
   input  logic              carry_in,
   input  logic              ovf_in,
   output logic [DATA_W-1:0] rslt_out,
   output logic              carry_out,
   output logic              ovf_out
);
   logic [NUM_LANES-1:0][DATA_W-1:0] lane_res;
   logic [NUM_LANES-1:0][DATA_W-1:0] lane_opd;
   logic [NUM_LANES-1:0]             lane_cf;
   logic [NUM_LANES-1:0]             lane_of;
   logic [NUM_LANES-1:0]             lane_zero;
   logic [NUM_LANES-1:0]             lane_one;
   logic [SEL_W-1:0]                 sel;

   generate
      if (NUM_LANES < 1 || NUM_LANES > (1 << SEL_W)) begin : g_bad_lanes
         $error("rtc_rotate_unit: NUM_LANES does not fit the width select");
      end
      if (NARROW_W < 2) begin : g_bad_narrow
         $error("rtc_rotate_unit: NARROW_W must be at least 2");
      end
      for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
         localparam int unsigned LW  = NARROW_W << g;
         localparam int unsigned EW  = rtc_pkg::eff_width(LW);
         logic [EW-1:0] eff;
         logic [LW-1:0] res;

         rtc_count_reduce #(
            .LANE_W (LW),
            .CNT_W  (CNT_W),
            .MASK_W (rtc_pkg::CNT_MASK_W)
         ) u_cnt (
            .cnt_raw (cnt_raw),
            .cnt_eff (eff)
         );

         rtc_ring_rotator #(
            .LANE_W (LW)
         ) u_rot (
            .val_in   (opd_in[LW-1:0]),   // R10: upper operand bits unused
            .cnt_eff  (eff),
            .go_right (rot_right),
            .cf_in    (carry_in),
            .of_in    (ovf_in),
            .val_out  (res),
            .cf_out   (lane_cf[g]),
            .of_out   (lane_of[g])
         );

         assign lane_res[g]  = DATA_W'(res);             // R9: zero-extend
         assign lane_opd[g]  = DATA_W'(opd_in[LW-1:0]);
         assign lane_zero[g] = (eff == EW'(0));
         assign lane_one[g]  = (eff == EW'(1));
      end
   endgenerate

   // codes past the last lane fold onto the widest lane (R9)
   assign sel = (32'(width_sel) >= NUM_LANES) ? SEL_W'(NUM_LANES - 1) : width_sel;

   assign rslt_out  = lane_res[sel];
   assign carry_out = lane_cf[sel];
   assign ovf_out   = lane_of[sel];

   always_comb begin
      if (lane_zero[sel]) begin
         AST_ZERO_HOLD: assert (rslt_out == lane_opd[sel] && carry_out == carry_in
                                && ovf_out == ovf_in)
            else $error("zero count changed state"); // R3
      end
      if (!lane_one[sel]) begin
         AST_OF_KEEP: assert (ovf_out == ovf_in)
            else $error("overflow changed on multi-bit count"); // R8
      end
      if (sel == SEL_W'(0)) begin
         AST_UPPER_CLEAR: assert (rslt_out[DATA_W-1:NARROW_W] == '0)
            else $error("bits above narrow width set"); // R9
      end
   end
endmodule

// File: tb/tb_rtc_rotate_unit.sv
`timescale 1ns/1ps
module tb_rtc_rotate_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] opd_in = '0;
   logic [7:0]  cnt_raw = '0;
   logic        rot_right = 1'b0;
   logic [1:0]  width_sel = '0;
   logic        carry_in = 1'b0;
   logic        ovf_in = 1'b0;
   logic [31:0] rslt_out;
   logic        carry_out;
   logic        ovf_out;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;   // 200 MHz

   rtc_rotate_unit dut (
      .opd_in    (opd_in),
      .cnt_raw   (cnt_raw),
      .rot_right (rot_right),
      .width_sel (width_sel),
      .carry_in  (carry_in),
      .ovf_in    (ovf_in),
      .rslt_out  (rslt_out),
      .carry_out (carry_out),
      .ovf_out   (ovf_out)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // Bit-serial reference: steps the (w+1)-bit ring one place per count.
   task automatic model(input logic [31:0] op, input int cnt, input bit dir,
                        input int ws, input bit cf, input bit of,
                        output logic [31:0] er, output bit ecf, output bit eof);
      int w;
      int n;
      logic [32:0] r;
      logic tmp;
      w = (ws == 0) ? 8 : (ws == 1) ? 16 : 32;
      n = (cnt & 31) % (w + 1);
      r = '0;
      for (int i = 0; i < w; i++) r[i] = op[i];
      r[w] = cf;
      for (int s = 0; s < n; s++) begin
         if (!dir) begin
            tmp = r[w];
            for (int b = w; b > 0; b--) r[b] = r[b-1];
            r[0] = tmp;
         end else begin
            tmp = r[0];
            for (int b = 0; b < w; b++) r[b] = r[b+1];
            r[w] = tmp;
         end
      end
      er = '0;
      for (int i = 0; i < w; i++) er[i] = r[i];
      ecf = r[w];
      eof = of;
      if (n == 1) eof = dir ? (cf ^ op[w-1]) : (ecf ^ er[w-1]);
   endtask

   task automatic drive(input logic [31:0] op, input int cnt, input bit dir,
                        input int ws, input bit cf, input bit of);
      @(negedge clk);
      opd_in = op; cnt_raw = 8'(cnt); rot_right = dir;
      width_sel = 2'(ws); carry_in = cf; ovf_in = of;
      #1;
   endtask

   task automatic run_case(input string req, input logic [31:0] op, input int cnt,
                           input bit dir, input int ws, input bit cf, input bit of);
      logic [31:0] er;
      bit ecf;
      bit eof;
      drive(op, cnt, dir, ws, cf, of);
      model(op, cnt, dir, ws, cf, of, er, ecf, eof);
      chk(req, "result", rslt_out, er);
      chk(req, "carry", 32'(carry_out), 32'(ecf));
      chk(req, "ovf", 32'(ovf_out), 32'(eof));
   endtask

   task automatic t_reset;
      @(negedge clk);
      chk("R3", "idle result", rslt_out, 32'h0);
      chk("R3", "idle carry", 32'(carry_out), 32'h0);
      chk("R3", "idle ovf", 32'(ovf_out), 32'h0);
   endtask

   task automatic t_known;
      // 8-bit left by 1: ring {0,81} -> {1,02}, of = 1 ^ 0
      drive(32'h81, 1, 1'b0, 0, 1'b0, 1'b0);
      chk("R4", "left1 result", rslt_out, 32'h02);
      chk("R4", "left1 carry", 32'(carry_out), 32'h1);
      chk("R6", "left1 ovf", 32'(ovf_out), 32'h1);
      // 8-bit right by 1: ring {1,01} -> {1,80}, of = 1 ^ 0
      drive(32'h01, 1, 1'b1, 0, 1'b1, 1'b0);
      chk("R5", "right1 result", rslt_out, 32'h80);
      chk("R5", "right1 carry", 32'(carry_out), 32'h1);
      chk("R7", "right1 ovf", 32'(ovf_out), 32'h1);
      // 16-bit left by 4 with carry in: bit 3 receives carry, bit 12 -> carry
      drive(32'h1000, 4, 1'b0, 1, 1'b1, 1'b0);
      chk("R4", "left4 result", rslt_out, 32'h0008);
      chk("R4", "left4 carry", 32'(carry_out), 32'h1);
      // 32-bit right by 3: carry into bit 29, bit 2 -> carry
      drive(32'h4, 3, 1'b1, 2, 1'b1, 1'b1);
      chk("R5", "right3 result", rslt_out, 32'h2000_0000);
      chk("R5", "right3 carry", 32'(carry_out), 32'h1);
      chk("R8", "right3 ovf kept", 32'(ovf_out), 32'h1);
   endtask

   task automatic t_count_mask;
      logic [31:0] r_ref;
      bit c_ref;
      bit o_ref;
      drive(32'h5A, 3, 1'b0, 0, 1'b1, 1'b0);
      r_ref = rslt_out; c_ref = carry_out; o_ref = ovf_out;
      drive(32'h5A, 8'hE3, 1'b0, 0, 1'b1, 1'b0);
      chk("R1", "upper count bits result", rslt_out, r_ref);
      chk("R1", "upper count bits carry", 32'(carry_out), 32'(c_ref));
      chk("R1", "upper count bits ovf", 32'(ovf_out), 32'(o_ref));
      run_case("R1", 32'hDEAD_BEEF, 8'h20, 1'b1, 2, 1'b1, 1'b1);
   endtask

   task automatic t_modulo;
      run_case("R2", 32'hA5, 9, 1'b0, 0, 1'b1, 1'b0);       // mod 9 -> 0
      run_case("R2", 32'hA5, 10, 1'b0, 0, 1'b1, 1'b0);      // mod 9 -> 1
      run_case("R2", 32'h8001, 17, 1'b1, 1, 1'b0, 1'b1);    // mod 17 -> 0
      run_case("R2", 32'h8001, 18, 1'b1, 1, 1'b1, 1'b0);    // mod 17 -> 1
      run_case("R2", 32'h8000_0001, 31, 1'b0, 2, 1'b1, 1'b0);
   endtask

   task automatic t_zero;
      drive(32'h0000_00C3, 18, 1'b0, 0, 1'b1, 1'b1);        // 18 mod 9 = 0
      chk("R3", "zero result", rslt_out, 32'hC3);
      chk("R3", "zero carry", 32'(carry_out), 32'h1);
      chk("R3", "zero ovf", 32'(ovf_out), 32'h1);
   endtask

   task automatic t_of_keep;
      run_case("R8", 32'h80, 2, 1'b0, 0, 1'b0, 1'b1);
      run_case("R8", 32'hFFFF, 7, 1'b1, 1, 1'b1, 1'b0);
   endtask

   task automatic t_width;
      drive(32'hFFFF_FF00, 0, 1'b0, 0, 1'b0, 1'b0);
      chk("R10", "upper operand ignored", rslt_out, 32'h0);
      drive(32'hFFFF_0081, 1, 1'b0, 0, 1'b0, 1'b0);
      chk("R9", "upper result cleared", rslt_out, 32'h02);
      chk("R10", "upper operand no carry", 32'(carry_out), 32'h1);
      drive(32'h8000_0001, 5, 1'b1, 3, 1'b1, 1'b0);
      begin
         logic [31:0] er; bit ecf; bit eof;
         model(32'h8000_0001, 5, 1'b1, 2, 1'b1, 1'b0, er, ecf, eof);
         chk("R9", "sel 3 as 32-bit result", rslt_out, er);
         chk("R9", "sel 3 as 32-bit carry", 32'(carry_out), 32'(ecf));
      end
   endtask

   task automatic t_sweep;
      logic [31:0] ops [4];
      ops[0] = 32'h8000_0001; ops[1] = 32'h1234_5678;
      ops[2] = 32'hFFFF_FFFE; ops[3] = 32'h0F0F_00F0;
      for (int ws = 0; ws < 4; ws++)
         for (int d = 0; d < 2; d++)
            for (int c = 0; c < 64; c++)
               for (int k = 0; k < 4; k++)
                  run_case("R4/R5 sweep", ops[k], c * 4 + (c & 3), d[0], ws, k[0], k[1]);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      t_reset();
      t_known();
      t_count_mask();
      t_modulo();
      t_zero();
      t_of_keep();
      t_width();
      t_sweep();
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule